// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a 32-bit RISC-V style core and decides, for each instruction, which address comes next. It takes the raw instruction word and the two source register values. It classifies the instruction as sequential, conditional branch, direct jump (jal) or register jump (jalr). It rebuilds the scrambled immediate of the branch or jump format and evaluates the branch condition. From these it selects the next PC.

For the two jump kinds it also presents the return address (current PC plus 4) and a write enable for the register file. The write enable is suppressed when the destination is register zero. A taken target whose bit 1 is set is reported on a flag instead of being loaded into the PC. The instruction class is an enumerated value (`K_SEQ`, `K_BRANCH`, `K_JAL`, `K_JALR`) chosen by a unique case on the opcode. The only stored state is the PC register. It moves along three paths: *reset* (to the reset address), *advance* (to PC+4 or to the taken target), and *hold* (step enable low, or a misaligned target).

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset loads the PC with 0x00000000, and the PC holds that value on the first cycle after reset is released.
- R2: While `step_en` is low the PC keeps its value at the clock edge, and `link_we` stays low.
- R3: Any instruction whose opcode (bits 6:0) is not 1100011, 1101111 or 1100111 moves the PC to PC+4, with `redirect` and `link_we` low.
- R4: A taken branch (opcode 1100011) loads PC plus the sign-extended offset {bit31, bit7, bits30:25, bits11:8, 0}, so the offset's bit 12 and bit 11 come from instruction bits 31 and 7.
- R5: funct3 (bits 14:12) 000 branches when the operands are equal, and 001 branches when they differ.
- R6: funct3 100 branches when rs1 < rs2, and 101 when rs1 >= rs2, both compared as signed two's complement.
- R7: funct3 110 branches when rs1 < rs2, and 111 when rs1 >= rs2, both compared as unsigned.
- R8: A branch whose condition is false, or whose funct3 is 010 or 011, moves the PC to PC+4 with `redirect` low.
- R9: jal (opcode 1101111) loads PC plus the sign-extended offset {bit31, bits19:12, bit20, bits30:21, 0} and presents PC+4 on `link_data`.
- R10: jalr (opcode 1100111) loads (rs1 + sign-extended bits 31:20) with bit 0 cleared and presents PC+4 on `link_data`.
- R11: `link_we` is high only for jal or jalr with `step_en` high, a destination field (bits 11:7) other than zero, and no misaligned flag.
- R12: When a taken target has bit 1 set, `misalign` is high and the PC keeps its value. A branch that is not taken never raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the PC at this edge |
| insn | input | 32 | Instruction at the current PC |
| rs1_val | input | 32 | First source operand |
| rs2_val | input | 32 | Second source operand |
| pc_q | output | 32 | Current program counter |
| link_data | output | 32 | Return address, PC+4 |
| link_we | output | 1 | Register write enable for the return address |
| redirect | output | 1 | Control transfer is taken |
| misalign | output | 1 | Taken target has bit 1 set |

## Verification
The bench builds branch and jump words from chosen offsets, so an immediate with one bit routed to the wrong place lands on a wrong PC. Offsets of -2048 and +4092 exercise the bit-12 and bit-11 positions of the branch format. A jal offset with bits 19, 11 and 2 set catches a swapped field. Operand pairs such as all-ones against one produce opposite results under signed and unsigned comparison, so a unit that mixes the two would branch the wrong way. A jalr base with bit 0 set checks that the low bit is cleared. Jumps to x0 and jumps with `step_en` low check that no link write escapes. Offsets of 2 and 6 check that the PC holds and the flag rises only when the transfer is taken.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [1:0] {
        K_SEQ,
        K_BRANCH,
        K_JAL,
        K_JALR
    } kind_e;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;

    localparam logic [2:0] F3_EQ  = 3'b000;
    localparam logic [2:0] F3_NE  = 3'b001;
    localparam logic [2:0] F3_LT  = 3'b100;
    localparam logic [2:0] F3_GE  = 3'b101;
    localparam logic [2:0] F3_LTU = 3'b110;
    localparam logic [2:0] F3_GEU = 3'b111;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     insn,
    output kind_e           kind,
    output logic [2:0]      f3,
    output logic            rd_nonzero,
    output logic [XLEN-1:0] imm_b,
    output logic [XLEN-1:0] imm_j,
    output logic [XLEN-1:0] imm_i
);
    localparam int BW = 13;
    localparam int JW = 21;
    localparam int IW = 12;

    logic [BW-1:0] raw_b;
    logic [JW-1:0] raw_j;
    logic [IW-1:0] raw_i;
    logic          unused_fields;

    assign unused_fields = ^insn[24:15];

    always_comb begin
        unique case (insn[6:0])
            OPC_BRANCH: kind = K_BRANCH;
            OPC_JAL:    kind = K_JAL;
            OPC_JALR:   kind = K_JALR;
            default:    kind = K_SEQ;
        endcase
    end

    assign f3         = insn[14:12];
    assign rd_nonzero = |insn[11:7];

    // scrambled fields put back in offset order
    assign raw_b = {insn[31], insn[7], insn[30:25], insn[11:8], 1'b0};
    assign raw_j = {insn[31], insn[19:12], insn[20], insn[30:21], 1'b0};
    assign raw_i = insn[31:20];

    assign imm_b = {{(XLEN-BW){raw_b[BW-1]}}, raw_b};
    assign imm_j = {{(XLEN-JW){raw_j[JW-1]}}, raw_j};
    assign imm_i = {{(XLEN-IW){raw_i[IW-1]}}, raw_i};

endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [2:0]      f3,
    output logic            take
);
    logic equal;
    logic lt_s;
    logic lt_u;

    assign equal = (a == b);
    assign lt_s  = ($signed(a) < $signed(b));
    assign lt_u  = (a < b);

    always_comb begin
        unique case (f3)
            F3_EQ:   take = equal;
            F3_NE:   take = !equal;
            F3_LT:   take = lt_s;
            F3_GE:   take = !lt_s;
            F3_LTU:  take = lt_u;
            F3_GEU:  take = !lt_u;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  kind_e           kind,
    input  logic            cond_take,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] imm_b,
    input  logic [XLEN-1:0] imm_j,
    input  logic [XLEN-1:0] imm_i,
    output logic            redirect,
    output logic [XLEN-1:0] target,
    output logic            misalign
);
    logic [XLEN-1:0] reg_sum;

    assign reg_sum = base + imm_i;

    always_comb begin
        unique case (kind)
            K_BRANCH: begin
                redirect = cond_take;
                target   = pc + imm_b;
            end
            K_JAL: begin
                redirect = 1'b1;
                target   = pc + imm_j;
            end
            K_JALR: begin
                redirect = 1'b1;
                target   = {reg_sum[XLEN-1:1], 1'b0};
            end
            default: begin
                redirect = 1'b0;
                target   = pc;
            end
        endcase
    end

    assign misalign = redirect && target[1];

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_en,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    output logic [XLEN-1:0] pc_q,
    output logic [XLEN-1:0] link_data,
    output logic            link_we,
    output logic            redirect,
    output logic            misalign
);
    localparam logic [XLEN-1:0] STEP     = XLEN'(4);
    localparam logic [XLEN-1:0] PC_START = XLEN'(RESET_PC);

    kind_e           kind;
    logic [2:0]      f3;
    logic            rd_nonzero;
    logic [XLEN-1:0] imm_b;
    logic [XLEN-1:0] imm_j;
    logic [XLEN-1:0] imm_i;
    logic            cond_take;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] pc_d;
    logic            is_jump;

    npc_decode #(.XLEN(XLEN)) u_decode (
        .insn       (insn),
        .kind       (kind),
        .f3         (f3),
        .rd_nonzero (rd_nonzero),
        .imm_b      (imm_b),
        .imm_j      (imm_j),
        .imm_i      (imm_i)
    );

    npc_cond #(.XLEN(XLEN)) u_cond (
        .a    (rs1_val),
        .b    (rs2_val),
        .f3   (f3),
        .take (cond_take)
    );

    npc_target #(.XLEN(XLEN)) u_target (
        .kind      (kind),
        .cond_take (cond_take),
        .pc        (pc_q),
        .base      (rs1_val),
        .imm_b     (imm_b),
        .imm_j     (imm_j),
        .imm_i     (imm_i),
        .redirect  (redirect),
        .target    (target),
        .misalign  (misalign)
    );

    assign seq_pc = pc_q + STEP;

    // next value: hold, advance sequentially or take the target
    always_comb begin
        if (!step_en || misalign) begin
            pc_d = pc_q;
        end else if (redirect) begin
            pc_d = target;
        end else begin
            pc_d = seq_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= PC_START;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign is_jump   = (kind == K_JAL) || (kind == K_JALR);
    assign link_data = seq_pc;
    assign link_we   = step_en && is_jump && rd_nonzero && !misalign;

    assert_reset_pc_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == PC_START));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(pc_q));

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
        (step_en && kind == K_SEQ) |=> (pc_q == $past(pc_q) + STEP));

    assert_pc_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        pc_q[1:0] == 2'b00);

    assert_no_link_x0_R11: assert property (@(posedge clk) disable iff (rst)
        (insn[11:7] == 5'd0) |-> !link_we);

    assert_misalign_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (step_en && misalign) |=> $stable(pc_q));

endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

    typedef struct {
        logic [31:0] pc_exp;
        logic        tk;
        logic        lwe;
        logic        mis;
        logic        jump;
        logic [31:0] link;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_en = 1'b0;
    logic [31:0] insn = 32'h0000_0013;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic [31:0] pc_q;
    logic [31:0] link_data;
    logic        link_we;
    logic        redirect;
    logic        misalign;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] mpc = '0;
    item_t       sb_q[$];
    bit          finished = 0;

    always #5 clk = ~clk;

    npc_unit u_npc_unit (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .insn      (insn),
        .rs1_val   (rs1_val),
        .rs2_val   (rs2_val),
        .pc_q      (pc_q),
        .link_data (link_data),
        .link_we   (link_we),
        .redirect  (redirect),
        .misalign  (misalign)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_b(input logic [12:0] o, input logic [2:0] f3);
        return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_j(input logic [20:0] o, input logic [4:0] rd);
        return {o[20], o[10:1], o[11], o[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_r(input logic [11:0] imm, input logic [4:0] rd);
        return {imm, 5'd1, 3'b000, rd, 7'b1100111};
    endfunction

    // driver: apply one instruction and push what the requirements predict
    task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                         input logic st, input logic tk, input logic jump,
                         input logic [31:0] tgt, input string tag);
        item_t it;
        @(negedge clk);
        insn = w; rs1_val = a; rs2_val = b; step_en = st;
        #1;
        it.tk   = tk;
        it.mis  = tk && tgt[1];
        it.jump = jump;
        it.link = mpc + 32'd4;
        it.lwe  = st && jump && (w[11:7] != 5'd0) && !it.mis;
        if (!st || it.mis)  it.pc_exp = mpc;
        else if (tk)        it.pc_exp = tgt;
        else                it.pc_exp = mpc + 32'd4;
        it.tag = tag;
        mpc = it.pc_exp;
        sb_q.push_back(it);
    endtask

    task automatic do_plain(input logic st, input string tag);
        apply(32'h0050_0093, 32'd0, 32'd0, st, 1'b0, 1'b0, 32'd0, tag);
    endtask

    task automatic do_br(input logic [2:0] f3, input int off, input logic [31:0] a,
                         input logic [31:0] b, input logic tk, input string tag);
        apply(enc_b(13'(off), f3), a, b, 1'b1, tk, 1'b0, mpc + 32'(off), tag);
    endtask

    task automatic do_jal(input int off, input logic [4:0] rd, input logic st, input string tag);
        apply(enc_j(21'(off), rd), 32'd0, 32'd0, st, 1'b1, 1'b1, mpc + 32'(off), tag);
    endtask

    task automatic do_jalr(input logic [31:0] base, input int imm, input logic [4:0] rd,
                           input string tag);
        logic [31:0] t;
        t = base + 32'(imm);
        t[0] = 1'b0;
        apply(enc_r(12'(imm), rd), base, 32'd0, 1'b1, 1'b1, 1'b1, t, tag);
    endtask

    // monitor: pop each expectation and compare against the design
    initial begin
        item_t it;
        forever begin
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            check32({it.tag, " redirect"}, {31'd0, redirect}, {31'd0, it.tk});
            check32({it.tag, " misalign"}, {31'd0, misalign}, {31'd0, it.mis});
            check32({it.tag, " link_we"},  {31'd0, link_we},  {31'd0, it.lwe});
            if (it.jump) check32({it.tag, " link_data"}, link_data, it.link);
            @(posedge clk);
            #1;
            check32({it.tag, " pc"}, pc_q, it.pc_exp);
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check32("R1 reset pc", pc_q, 32'h0);
        @(posedge clk);
        #1;
        check32("R1 pc after release", pc_q, 32'h0);

        do_plain(1'b1, "R3 sequential step");
        do_plain(1'b0, "R2 step_en low holds");
        do_br(3'b000, 16, 32'd7, 32'd7, 1'b1, "R5 R4 beq equal");
        do_br(3'b000, 16, 32'd7, 32'd8, 1'b0, "R8 beq unequal");
        do_br(3'b001, -8, 32'd1, 32'd2, 1'b1, "R5 bne backward");
        do_br(3'b100, 12, 32'hFFFF_FFFF, 32'd1, 1'b1, "R6 blt signed");
        do_br(3'b110, 12, 32'hFFFF_FFFF, 32'd1, 1'b0, "R7 bltu unsigned");
        do_br(3'b101, 8, 32'd5, 32'd5, 1'b1, "R6 bge equal");
        do_br(3'b101, 8, 32'hFFFF_FFFD, 32'd2, 1'b0, "R6 bge negative");
        do_br(3'b111, 8, 32'hFFFF_FFFF, 32'd1, 1'b1, "R7 bgeu unsigned");
        do_br(3'b010, 8, 32'd3, 32'd3, 1'b0, "R8 funct3 010");
        do_br(3'b000, -2048, 32'd0, 32'd0, 1'b1, "R4 offset -2048");
        do_br(3'b000, 4092, 32'd0, 32'd0, 1'b1, "R4 offset +4092");
        do_jal(32'h0008_0804, 5'd1, 1'b1, "R9 R11 jal far");
        do_jal(-32'sh0008_1000, 5'd0, 1'b1, "R9 R11 jal to x0");
        do_jalr(32'h0000_0100, -4, 5'd0, "R10 R11 jalr return");
        do_jalr(32'h0000_0201, 0, 5'd5, "R10 jalr bit0 cleared");
        do_br(3'b000, 6, 32'd1, 32'd1, 1'b1, "R12 branch misaligned");
        do_br(3'b000, 6, 32'd1, 32'd2, 1'b0, "R12 not taken no flag");
        do_jal(2, 5'd1, 1'b1, "R12 jal misaligned");
        do_jalr(32'h0000_0300, 2, 5'd1, "R12 jalr misaligned");
        do_jal(16, 5'd1, 1'b0, "R2 R11 jal with step_en low");
        do_plain(1'b1, "R3 sequential after hold");

        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        #2;
        finish_run();
    end

endmodule